// File: doc/BRIEF.md
# Calibration Gain/Offset Extractor

This block turns seven packed calibration bytes into per-channel linear correction coefficients. The bytes hold a high and a low reference code for three measurement groups: main charger voltage (group 0), battery temperature and auxiliary inputs (group 1) and battery voltage (group 2). Each byte comes with a flag that says whether its read from one-time-programmable storage succeeded. The bytes must already be fetched when the block starts.

A one-cycle `start_i` takes a snapshot of the bytes and flags. The block then handles the groups in order 0, 1, 2. It does this through one shared restoring divider, which produces one quotient bit per clock. For each usable group it produces an unsigned scaled gain in units of 1/1000 mV per code. It also produces a signed offset in the same scale. A raw-to-physical converter downstream computes `(code * gain + offset) / 1000`. A one-cycle `done_o` marks the moment all three results are in place.

Top module: `cal_coef_extract`

## Requirements
- R1: Byte k is `cal_bytes_i[8k+7:8k]`. The group 0 high code, from MSB to LSB, is byte0[1:0], then byte1[5:0], then byte2[7:6]. Its low code is byte2[5:1]. Bits byte0[7:2] and byte1[7:6] have no effect.
- R2: The group 1 high code, from MSB to LSB, is byte2[0], then byte3[7:0], then byte4[7]. Its low code is byte4[6:2].
- R3: The group 2 high code, from MSB to LSB, is byte4[1:0], then byte5[7:0]. Its low code is byte6[7:2]. Bits byte6[1:0] have no effect.
- R4: For a usable group, gain = floor(1000*(Vh-Vl)/(hi-lo)), with (Vh,Vl) in mV equal to (19500,315) for group 0, (1300,21) for group 1 and (4700,2380) for group 2. Gain g sits at `gain_o[32g+31:32g]`.
- R5: For a usable group, offset = 1000*Vh - gain*hi, using the truncated gain and taken modulo 2^32 as a two's-complement value. Offset g sits at `offset_o[32g+31:32g]`.
- R6: A group whose byte window has any flag low gives gain 0, offset 0 and `grp_valid_o[g]`=0. The windows are bytes 0..2 for group 0, 2..4 for group 1 and 4..6 for group 2, and flag k is `byte_ok_i[k]`.
- R7: A group with hi <= lo gives gain 0, offset 0 and valid 0, and no division is attempted for it.
- R8: `start_i` while idle raises `busy_o` on the next cycle. After all three groups are handled, `done_o` is high for exactly one cycle, and `busy_o` is low in the cycle after it.
- R9: After `done_o`, the outputs hold their values while the block is idle, whatever the data inputs do.
- R10: `start_i` asserted while `busy_o` is high is ignored. The run continues with its original data and keeps its length.
- R11: The bytes and flags are sampled only on the accepted `start_i`. Later changes to them do not affect that run.
- R12: After reset, `busy_o`, `done_o`, `grp_valid_o`, `gain_o` and `offset_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse |
| cal_bytes_i | input | 56 | Seven packed calibration bytes, byte k at [8k+7:8k] |
| byte_ok_i | input | 7 | Per-byte read-success flags |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| grp_valid_o | output | 3 | Per-group calibration valid |
| gain_o | output | 96 | Three unsigned 32-bit gains |
| offset_o | output | 96 | Three signed 32-bit offsets |

## Verification
The bench first applies the nominal factory codes. Next, it sweeps all 128 flag patterns against those codes, which checks that each group's validity depends on its own three-byte window and on nothing else. A sweep of arithmetically generated codes follows, with the unused byte bits set alternately to zero and one. This catches a field bit placed in the wrong position or an unused bit leaking into a field. Edge codes (equal, reversed, adjacent, and full-range pairs) check the invalid branch, the largest quotient and offset wrap-around. Runs that change the inputs or pulse start again mid-run separate a proper snapshot from live sampling.

// File: rtl/cal_pkg.sv
// Shared constants, the per-group code record and the reference-voltage
// tables used by the calibration coefficient extractor.
package cal_pkg;
    localparam int NBYTES = 7;
    localparam int NGRP   = 3;
    localparam int CODE_W = 10;
    localparam int COEF_W = 32;
    localparam int SCALE  = 1000;
    localparam int GIDX_W = $clog2(NGRP);

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
        logic              usable;
    } grp_code_t;

    // Upper reference input in mV for a group.
    function automatic logic [COEF_W-1:0] ref_hi_mv(input logic [GIDX_W-1:0] g);
        case (g)
            GIDX_W'(0): ref_hi_mv = COEF_W'(19500);
            GIDX_W'(1): ref_hi_mv = COEF_W'(1300);
            default:    ref_hi_mv = COEF_W'(4700);
        endcase
    endfunction

    // Lower reference input in mV for a group.
    function automatic logic [COEF_W-1:0] ref_lo_mv(input logic [GIDX_W-1:0] g);
        case (g)
            GIDX_W'(0): ref_lo_mv = COEF_W'(315);
            GIDX_W'(1): ref_lo_mv = COEF_W'(21);
            default:    ref_lo_mv = COEF_W'(2380);
        endcase
    endfunction
endpackage

// File: rtl/cal_unpack.sv
// Unpacks the high and low codes of every group from the packed byte
// snapshot and decides whether each group can be calibrated.
// Assumes three groups whose byte windows start at byte 2*g, three bytes wide.
module cal_unpack
    import cal_pkg::*;
(
    input  logic [NBYTES*8-1:0]        bytes_i,
    input  logic [NBYTES-1:0]          ok_i,
    output grp_code_t [NGRP-1:0]       grp_o
);
    logic [7:0] b [NBYTES];
    logic [CODE_W-1:0] hi [NGRP];
    logic [CODE_W-1:0] lo [NGRP];

    // Split the flat vector into bytes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign b[k] = bytes_i[8*k +: 8];
    end

    // Field layout: codes cross byte boundaries.
    assign hi[0] = {b[0][1:0], b[1][5:0], b[2][7:6]};
    assign lo[0] = CODE_W'(b[2][5:1]);
    assign hi[1] = {b[2][0], b[3], b[4][7]};
    assign lo[1] = CODE_W'(b[4][6:2]);
    assign hi[2] = {b[4][1:0], b[5]};
    assign lo[2] = CODE_W'(b[6][7:2]);

    // A group is usable when its whole window read fine and hi exceeds lo.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_o[g].hi     = hi[g];
        assign grp_o[g].lo     = lo[g];
        assign grp_o[g].usable = (&ok_i[2*g+2 -: 3]) && (hi[g] > lo[g]);
    end
endmodule

// File: rtl/cal_divider.sv
// Restoring unsigned divider, one quotient bit per clock.
// Assumes den is nonzero; num and den are captured on start while idle.
// done pulses in the cycle quo first holds the final quotient.
module cal_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W-1:0] rem, den_q;
    logic [NUM_W-1:0] q;
    logic [DEN_W:0]   rem_sh, diff;
    logic             ge;

    // Trial subtraction of one restoring step.
    always_comb begin
        rem_sh = {rem, q[NUM_W-1]};
        diff   = rem_sh - {1'b0, den_q};
        ge     = rem_sh >= {1'b0, den_q};
    end

    // Iteration state: load, shift NUM_W times, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            rem     <= '0;
            den_q   <= '0;
            q       <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                q       <= num;
                rem     <= '0;
                den_q   <= den;
                cnt     <= CNT_W'(NUM_W);
                running <= 1'b1;
            end else if (running) begin
                rem <= ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                q   <= {q[NUM_W-2:0], ge};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quo = q;
endmodule

// File: rtl/cal_offset.sv
// Offset term: base minus gain times high code, kept modulo 2^OFS_W.
// Assumes gain is already the truncated quotient.
module cal_offset #(
    parameter int GAIN_W = 32,
    parameter int CODE_W = 10,
    parameter int OFS_W  = 32
) (
    input  logic [GAIN_W-1:0]       gain_i,
    input  logic [CODE_W-1:0]       code_hi_i,
    input  logic [OFS_W-1:0]        base_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    localparam int PROD_W = GAIN_W + CODE_W;

    logic [PROD_W-1:0] prod;

    // Full product, then wrap-around subtraction.
    always_comb begin
        prod  = PROD_W'(gain_i) * PROD_W'(code_hi_i);
        ofs_o = $signed(base_i - prod[OFS_W-1:0]);
    end
endmodule

// File: rtl/cal_coef_extract.sv
// Top: snapshots the calibration bytes on start, walks the groups in
// order through one shared divider and offset stage, and pulses done.
// Assumes start is a pulse; starts while busy are ignored.
module cal_coef_extract
    import cal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NBYTES*8-1:0]      cal_bytes_i,
    input  logic [NBYTES-1:0]        byte_ok_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [NGRP-1:0]          grp_valid_o,
    output logic [NGRP*COEF_W-1:0]   gain_o,
    output logic [NGRP*COEF_W-1:0]   offset_o
);
    typedef enum logic [1:0] {S_IDLE, S_PREP, S_WAIT} state_t;

    state_t                         st;
    logic [GIDX_W-1:0]              gidx;
    logic [NBYTES*8-1:0]            bytes_q;
    logic [NBYTES-1:0]              ok_q;
    grp_code_t [NGRP-1:0]           grp;
    grp_code_t                      cur;
    logic                           last_grp;
    logic                           div_start, div_done;
    logic [COEF_W-1:0]              div_num, div_quo;
    logic [CODE_W-1:0]              div_den;
    logic signed [COEF_W-1:0]       ofs;
    logic [NGRP-1:0][COEF_W-1:0]    gain_q, ofs_q;
    logic [NGRP-1:0]                vld_q;
    logic                           done_q;

    cal_unpack i_unpack (
        .bytes_i (bytes_q),
        .ok_i    (ok_q),
        .grp_o   (grp)
    );

    // Operands of the group under work.
    always_comb begin
        cur       = grp[gidx];
        last_grp  = (gidx == GIDX_W'(NGRP - 1));
        div_num   = COEF_W'(SCALE) * (ref_hi_mv(gidx) - ref_lo_mv(gidx));
        div_den   = cur.hi - cur.lo;
        div_start = (st == S_PREP) && cur.usable;
    end

    cal_divider #(.NUM_W(COEF_W), .DEN_W(CODE_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    cal_offset #(.GAIN_W(COEF_W), .CODE_W(CODE_W), .OFS_W(COEF_W)) i_ofs (
        .gain_i    (div_quo),
        .code_hi_i (cur.hi),
        .base_i    (COEF_W'(SCALE) * ref_hi_mv(gidx)),
        .ofs_o     (ofs)
    );

    // Sequencer: capture, per-group divide or skip, result write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            gidx    <= '0;
            bytes_q <= '0;
            ok_q    <= '0;
            gain_q  <= '0;
            ofs_q   <= '0;
            vld_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_i) begin
                        bytes_q <= cal_bytes_i;
                        ok_q    <= byte_ok_i;
                        gain_q  <= '0;
                        ofs_q   <= '0;
                        vld_q   <= '0;
                        gidx    <= '0;
                        st      <= S_PREP;
                    end
                end
                S_PREP: begin
                    if (cur.usable) begin
                        st <= S_WAIT;
                    end else begin
                        gain_q[gidx] <= '0;
                        ofs_q[gidx]  <= '0;
                        vld_q[gidx]  <= 1'b0;
                        if (last_grp) begin
                            st     <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            gidx <= gidx + GIDX_W'(1);
                            st   <= S_PREP;
                        end
                    end
                end
                S_WAIT: begin
                    if (div_done) begin
                        gain_q[gidx] <= div_quo;
                        ofs_q[gidx]  <= ofs;
                        vld_q[gidx]  <= 1'b1;
                        if (last_grp) begin
                            st     <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            gidx <= gidx + GIDX_W'(1);
                            st   <= S_PREP;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy_o      = (st != S_IDLE);
    assign done_o      = done_q;
    assign grp_valid_o = vld_q;
    assign gain_o      = gain_q;
    assign offset_o    = ofs_q;
endmodule

// File: rtl/cal_coef_extract_chk.sv
// Protocol and result-shape checks for cal_coef_extract, bound to the top.
module cal_coef_extract_chk
    import cal_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [NGRP-1:0]        grp_valid_o,
    input logic [NGRP*COEF_W-1:0] gain_o,
    input logic [NGRP*COEF_W-1:0] offset_o
);
    // R8: completion is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: block is idle right after completion.
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R8: an accepted start makes the block busy.
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R9: results stay put while idle and not restarted.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(gain_o) && $stable(offset_o) && $stable(grp_valid_o)));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // R6: an invalid group reports zero coefficients.
        a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && !grp_valid_o[g]) |-> (gain_o[g*COEF_W +: COEF_W] == '0 &&
                                            offset_o[g*COEF_W +: COEF_W] == '0));
        // R4: a valid group never has a zero gain.
        a_r4_valid_gain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && grp_valid_o[g]) |-> (gain_o[g*COEF_W +: COEF_W] != '0));
    end
endmodule

bind cal_coef_extract cal_coef_extract_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .grp_valid_o (grp_valid_o),
    .gain_o      (gain_o),
    .offset_o    (offset_o)
);

// File: tb/test_cal_coef_extract.sv
module test_cal_coef_extract;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [55:0] cal_bytes_i = '0;
    logic [6:0]  byte_ok_i = '0;
    logic        busy_o, done_o;
    logic [2:0]  grp_valid_o;
    logic [95:0] gain_o, offset_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_len = 0;

    always #10 clk = ~clk;

    cal_coef_extract i_cal_coef_extract (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_bytes_i(cal_bytes_i),
        .byte_ok_i(byte_ok_i), .busy_o(busy_o), .done_o(done_o),
        .grp_valid_o(grp_valid_o), .gain_o(gain_o), .offset_o(offset_o)
    );

    // Global watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [55:0] pack(input int mh, ml, th, tl, bh, bl, input bit fill);
        logic [7:0] b [7];
        b[0] = {fill ? 6'h3f : 6'h00, mh[9:8]};
        b[1] = {fill ? 2'b11 : 2'b00, mh[7:2]};
        b[2] = {mh[1:0], ml[4:0], th[9]};
        b[3] = th[8:1];
        b[4] = {th[0], tl[4:0], bh[9:8]};
        b[5] = bh[7:0];
        b[6] = {bl[5:0], fill ? 2'b11 : 2'b00};
        return {b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
    endfunction

    // Launch one run; optional mid-run disturbance (restart + input change).
    task automatic run(input int mh, ml, th, tl, bh, bl, input logic [6:0] ok,
                       input bit fill, input bit disturb);
        int hi [3];
        int lo [3];
        longint vh [3];
        longint vl [3];
        longint eg, eo;
        bit ev, rd;
        string gt;
        int len;
        hi = '{mh, th, bh}; lo = '{ml, tl, bl};
        vh = '{19500, 1300, 4700}; vl = '{315, 21, 2380};
        @(negedge clk);
        cal_bytes_i = pack(mh, ml, th, tl, bh, bl, fill);
        byte_ok_i = ok;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy after start", busy_o, 1);
        len = 1;
        if (disturb) begin
            // R11: inputs change after acceptance
            cal_bytes_i = ~cal_bytes_i;
            byte_ok_i = ~ok;
            repeat (9) @(negedge clk);
            len += 9;
            // R10: start while busy must be ignored
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            len += 1;
        end
        while (!done_o && len < 1000) begin
            @(negedge clk);
            len++;
        end
        check("R8 done seen", done_o, 1);
        if (disturb) check("R10 run length unchanged by restart", len, last_len);
        else last_len = len;
        for (int g = 0; g < 3; g++) begin
            rd = ((ok >> (2 * g)) & 7'h7) == 7'h7;
            gt = (g == 0) ? "R1" : (g == 1) ? "R2" : "R3";
            if (!rd) gt = "R6";
            else if (hi[g] <= lo[g]) gt = "R7";
            if (disturb) gt = {gt, "/R11"};
            ev = rd && (hi[g] > lo[g]);
            eg = ev ? (1000 * (vh[g] - vl[g])) / (hi[g] - lo[g]) : 0;
            eo = ev ? longint'($signed(32'(1000 * vh[g] - eg * hi[g]))) : 0;
            check({gt, "/R4 gain"}, gain_o[32*g +: 32], eg);
            check({gt, "/R5 offset"}, longint'($signed(offset_o[32*g +: 32])), eo);
            check({gt, " valid"}, grp_valid_o[g], ev);
        end
        @(negedge clk);
        check("R8 done single cycle", done_o, 0);
        check("R8 idle after done", busy_o, 0);
    endtask

    // R9: outputs hold while idle even though inputs move.
    task automatic hold_check();
        logic [95:0] g0, o0;
        logic [2:0] v0;
        g0 = gain_o; o0 = offset_o; v0 = grp_valid_o;
        cal_bytes_i = 56'h0123456789abcd;
        byte_ok_i = 7'h55;
        repeat (5) @(negedge clk);
        check("R9 gain hold", gain_o == g0, 1);
        check("R9 offset hold", offset_o == o0, 1);
        check("R9 valid hold", grp_valid_o == v0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 busy", busy_o, 0);
        check("R12 done", done_o, 0);
        check("R12 valid", grp_valid_o, 0);
        check("R12 gain", gain_o == '0, 1);
        check("R12 offset", offset_o == '0, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Nominal factory codes, all reads ok, then with filler bits set.
        run(997, 16, 985, 16, 982, 33, 7'h7f, 0, 0);
        run(997, 16, 985, 16, 982, 33, 7'h7f, 1, 0);
        hold_check();
        // Same codes with restart and input change mid-run.
        run(997, 16, 985, 16, 982, 33, 7'h7f, 0, 1);

        // R6: every flag pattern.
        for (int m = 0; m < 128; m++)
            run(997, 16, 985, 16, 982, 33, 7'(m), m[0], 0);

        // R1/R2/R3: sweep of generated codes.
        for (int i = 0; i < 64; i++)
            run((i * 37 + 500) % 1024, i % 32, (i * 53) % 1024, (i * 7) % 32,
                (i * 91 + 3) % 1024, (i * 5) % 64, 7'h7f, i[0], 0);

        // R7 and boundary codes.
        run(20, 20, 5, 5, 63, 63, 7'h7f, 0, 0);
        run(10, 20, 3, 30, 40, 50, 7'h7f, 1, 0);
        run(32, 31, 32, 31, 64, 63, 7'h7f, 0, 0);
        run(1023, 0, 1023, 0, 1023, 0, 7'h7f, 1, 0);
        run(1023, 31, 1023, 31, 1023, 63, 7'h7f, 0, 0);
        run(1, 0, 1, 0, 1, 0, 7'h7f, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule